// File: doc/BRIEF.md
# Step-gated multicycle CPU controller

This block is the control unit of a very small teaching processor. Each instruction passes through three states: fetch, decode and one execute state picked by the opcode. Every move between states waits for an external step strobe, so a user can walk the machine one state at a time from a push button or from a debug script. The controller holds the program counter and the instruction register. It drives a 4-bit address bus that the instruction ROM and a small read/write data memory share, together with the read/write select and the register-file and ALU controls.

The instruction word is 12 bits wide: opcode in bits 11:8, register field in bits 7:4, and an immediate value or memory address in bits 3:0. Opcode 0 writes the ALU result to the register named by the register field. Opcode 1 loads from data memory, 2 stores to data memory and 3 loads the immediate value. Any other opcode does nothing, but it still takes its three steps and advances the program counter. The ALU, the register-file storage and both memories sit outside the block.

Top module: `step_cpu_ctrl`

## Requirements
- R1: The active-low reset clears the program counter to 0 at once, without waiting for a clock edge, and puts the controller in fetch.
- R2: While step_i is low the state, the program counter and the instruction register hold, and rf_we_o stays 0.
- R3: In fetch, rd_o is 1 with no input asking for it, and addr_o equals bits 3:0 of the program counter.
- R4: In fetch, ir_load_o equals step_i. The word on data_i is captured on the edge that leaves fetch, and later changes on data_i do not alter how that instruction is decoded.
- R5: A step in fetch always moves to decode, a step in decode always moves to an execute state, and a step in any execute state returns to fetch, so one instruction takes exactly three steps. ir_load_o is 0 outside fetch.
- R6: Opcode 0, in its execute state with step_i high: rf_we_o=1, rf_waddr_o=bits 7:4, rf_wdata_o=alu_res_i, and alu_fn_o=bits 3:0 of the instruction.
- R7: Opcode 1, in its execute state: rd_o=1 and addr_o=bits 3:0 of the instruction. With step_i high, rf_we_o=1, rf_waddr_o=bits 7:4 and rf_wdata_o=data_i[3:0].
- R8: Opcode 2, in its execute state: rd_o=0, addr_o=bits 3:0, rf_raddr_o=bits 7:4, wdata_o=rf_rdata_i and rf_we_o=0. rd_o is 0 in no other state.
- R9: Opcode 3, in its execute state with step_i high: rf_we_o=1, rf_waddr_o=bits 7:4, rf_wdata_o=bits 3:0 of the instruction.
- R10: Opcodes 4 to 15 write no register, keep rd_o at 1, and still advance the program counter after three steps.
- R11: The 16-bit program counter rises by exactly 1 on the step that leaves an execute state, and at no other time. addr_o wraps to 0 when the counter reaches 16.
- R12: rf_we_o is high for one clock per instruction only: in an execute state, and only while step_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance strobe; the state moves on an edge where it is high |
| data_i | input | 12 | Shared read data: instruction word in fetch, memory data in bits 3:0 during a load |
| alu_res_i | input | 4 | Result from the external ALU |
| rf_rdata_i | input | 4 | Register-file read data for the register on rf_raddr_o |
| addr_o | output | 4 | Shared address bus for the ROM and the data memory |
| rd_o | output | 1 | Read/write select: 1 read, 0 write |
| ir_load_o | output | 1 | Instruction-register capture strobe |
| alu_fn_o | output | 4 | ALU function code (instruction bits 3:0) |
| rf_raddr_o | output | 4 | Register-file read index (instruction bits 7:4) |
| rf_we_o | output | 1 | Register-file write enable, one clock |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 4 | Register-file write data |
| wdata_o | output | 4 | Data-memory write data |
| pc_o | output | 16 | Program counter |

## Verification
A table of instructions covers every opcode class. ALU writes, loads, stores, immediate loads and two unused opcodes each use different register fields, address fields and return data, so a wrong field slice or a swapped write-data source shows up as a wrong index or value. Between capture and execute the bench puts a different word on data_i, which tells a design that decodes the registered word from one that decodes the live bus. It also holds step low in several states to tell a design that waits from one that moves on its own. It runs enough instructions to take the counter past 15, and it pulls reset in the middle of an instruction.

// File: rtl/step_cpu_pkg.sv
package step_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ALU,
    ST_LOAD,
    ST_STORE,
    ST_LDI,
    ST_NOP
  } state_e;

  localparam logic [OP_W-1:0] OP_ALU   = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_LDI   = 4'd3;
endpackage

// File: rtl/step_cpu_pc.sv
module step_cpu_pc #(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (inc_i) pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;

  assert_pc_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> pc_q == $past(pc_q) + 1'b1);
  assert_pc_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(pc_q));
endmodule

// File: rtl/step_cpu_seq.sv
module step_cpu_seq
  import step_cpu_pkg::*;
#(
  parameter int FLD_W = 4,
  localparam int IW = OP_W + 2 * FLD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [IW-1:0] data_i,
  output state_e        state_o,
  output logic [IW-1:0] ir_o,
  output logic          ir_load_o,
  output logic          pc_inc_o
);
  state_e          state_q, state_nx;
  logic [IW-1:0]   ir_q;
  logic [OP_W-1:0] opcode;
  logic            in_exec;

  assign opcode  = ir_q[IW-1 -: OP_W];
  assign in_exec = state_q inside {ST_ALU, ST_LOAD, ST_STORE, ST_LDI, ST_NOP};

  always_comb begin
    state_nx = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_ALU:   state_nx = ST_ALU;
          OP_LOAD:  state_nx = ST_LOAD;
          OP_STORE: state_nx = ST_STORE;
          OP_LDI:   state_nx = ST_LDI;
          default:  state_nx = ST_NOP;
        endcase
      end
      default:   state_nx = ST_FETCH;
    endcase
  end

  assign ir_load_o = step_i && (state_q == ST_FETCH);
  assign pc_inc_o  = step_i && in_exec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
    end else begin
      if (step_i)    state_q <= state_nx;
      if (ir_load_o) ir_q    <= data_i;
    end
  end

  assign state_o = state_q;
  assign ir_o    = ir_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q) && $stable(ir_q));
  assert_fetch_to_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && state_q == ST_FETCH) |=> state_q == ST_DECODE);
  assert_exec_to_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> state_q == ST_FETCH);
  assert_ir_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |=> ir_q == $past(data_i));
  assert_nop_decode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && state_q == ST_DECODE && opcode > OP_LDI) |=> state_q == ST_NOP);
endmodule

// File: rtl/step_cpu_out.sv
module step_cpu_out
  import step_cpu_pkg::*;
#(
  parameter int FLD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  state_e           state_i,
  input  logic             step_i,
  input  logic [FLD_W-1:0] pc_lo_i,
  input  logic [FLD_W-1:0] reg_fld_i,
  input  logic [FLD_W-1:0] low_fld_i,
  input  logic [FLD_W-1:0] data_lo_i,
  input  logic [FLD_W-1:0] alu_res_i,
  input  logic [FLD_W-1:0] rf_rdata_i,
  output logic [FLD_W-1:0] addr_o,
  output logic             rd_o,
  output logic [FLD_W-1:0] alu_fn_o,
  output logic [FLD_W-1:0] rf_raddr_o,
  output logic             rf_we_o,
  output logic [FLD_W-1:0] rf_waddr_o,
  output logic [FLD_W-1:0] rf_wdata_o,
  output logic [FLD_W-1:0] wdata_o
);
  logic mem_phase;

  assign mem_phase = state_i inside {ST_LOAD, ST_STORE};

  // shared bus: data address only while a memory instruction executes
  assign addr_o     = mem_phase ? low_fld_i : pc_lo_i;
  assign rd_o       = (state_i != ST_STORE);
  assign alu_fn_o   = low_fld_i;
  assign rf_raddr_o = reg_fld_i;
  assign wdata_o    = rf_rdata_i;
  assign rf_waddr_o = reg_fld_i;

  // write on the leaving edge only, so a held step gives one write
  assign rf_we_o = step_i && (state_i inside {ST_ALU, ST_LOAD, ST_LDI});

  always_comb begin
    unique case (state_i)
      ST_ALU:  rf_wdata_o = alu_res_i;
      ST_LOAD: rf_wdata_o = data_lo_i;
      default: rf_wdata_o = low_fld_i;
    endcase
  end

  assert_we_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);
  assert_no_dual_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, !rd_o}));
  assert_fetch_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |-> rd_o);
endmodule

// File: rtl/step_cpu_ctrl.sv
module step_cpu_ctrl
  import step_cpu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int FLD_W = 4,
  localparam int IW = OP_W + 2 * FLD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [IW-1:0]    data_i,
  input  logic [FLD_W-1:0] alu_res_i,
  input  logic [FLD_W-1:0] rf_rdata_i,
  output logic [FLD_W-1:0] addr_o,
  output logic             rd_o,
  output logic             ir_load_o,
  output logic [FLD_W-1:0] alu_fn_o,
  output logic [FLD_W-1:0] rf_raddr_o,
  output logic             rf_we_o,
  output logic [FLD_W-1:0] rf_waddr_o,
  output logic [FLD_W-1:0] rf_wdata_o,
  output logic [FLD_W-1:0] wdata_o,
  output logic [PC_W-1:0]  pc_o
);
  state_e        state;
  logic [IW-1:0] ir;
  logic          pc_inc;

  step_cpu_pc #(.PC_W(PC_W)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (pc_inc),
    .pc_o  (pc_o)
  );

  step_cpu_seq #(.FLD_W(FLD_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .data_i   (data_i),
    .state_o  (state),
    .ir_o     (ir),
    .ir_load_o(ir_load_o),
    .pc_inc_o (pc_inc)
  );

  step_cpu_out #(.FLD_W(FLD_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .step_i    (step_i),
    .pc_lo_i   (pc_o[FLD_W-1:0]),
    .reg_fld_i (ir[2*FLD_W-1:FLD_W]),
    .low_fld_i (ir[FLD_W-1:0]),
    .data_lo_i (data_i[FLD_W-1:0]),
    .alu_res_i (alu_res_i),
    .rf_rdata_i(rf_rdata_i),
    .addr_o    (addr_o),
    .rd_o      (rd_o),
    .alu_fn_o  (alu_fn_o),
    .rf_raddr_o(rf_raddr_o),
    .rf_we_o   (rf_we_o),
    .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o),
    .wdata_o   (wdata_o)
  );

  assert_reset_pc_R1: assert property (@(posedge clk_i)
    !rst_ni |-> pc_o == '0);
endmodule

// File: tb/sim_step_cpu_ctrl.sv
module sim_step_cpu_ctrl;
  typedef struct packed {
    logic [11:0] instr;
    logic [3:0]  ld;    // memory data on a load, register data on a store
    logic [3:0]  alu;
    logic        we;
    logic [3:0]  wa;
    logic [3:0]  wd;
    logic        rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{12'h053, 4'h0, 4'h9, 1'b1, 4'h5, 4'h9, 1'b1},
    '{12'h1A7, 4'hC, 4'h0, 1'b1, 4'hA, 4'hC, 1'b1},
    '{12'h2B4, 4'h6, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0},
    '{12'h32E, 4'h0, 4'h0, 1'b1, 4'h2, 4'hE, 1'b1},
    '{12'h7F1, 4'h0, 4'h0, 1'b0, 4'h0, 4'h0, 1'b1},
    '{12'h3F0, 4'h0, 4'h0, 1'b1, 4'hF, 4'h0, 1'b1},
    '{12'h0C8, 4'h0, 4'h3, 1'b1, 4'hC, 4'h3, 1'b1},
    '{12'hF00, 4'h0, 4'h0, 1'b0, 4'h0, 4'h0, 1'b1},
    '{12'h10F, 4'h5, 4'h0, 1'b1, 4'h0, 4'h5, 1'b1},
    '{12'h2E0, 4'hA, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic [11:0] data_i = '0;
  logic [3:0]  alu_res_i = '0;
  logic [3:0]  rf_rdata_i = '0;
  logic [3:0]  addr_o, alu_fn_o, rf_raddr_o, rf_waddr_o, rf_wdata_o, wdata_o;
  logic        rd_o, ir_load_o, rf_we_o;
  logic [15:0] pc_o;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_pc = '0;

  always #5 clk_i = ~clk_i;

  step_cpu_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .data_i(data_i),
    .alu_res_i(alu_res_i), .rf_rdata_i(rf_rdata_i), .addr_o(addr_o),
    .rd_o(rd_o), .ir_load_o(ir_load_o), .alu_fn_o(alu_fn_o),
    .rf_raddr_o(rf_raddr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .wdata_o(wdata_o), .pc_o(pc_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v, input int hold);
    logic [3:0] op, exp_addr;
    op = v.instr[11:8];
    exp_addr = (op == 4'd1 || op == 4'd2) ? v.instr[3:0] : exp_pc[3:0];
    // fetch
    data_i = v.instr; step_i = 1'b0; #1;
    chk("R3 addr", {12'h0, addr_o}, {12'h0, exp_pc[3:0]});
    chk("R3 rd", {15'h0, rd_o}, 16'h1);
    chk("R4 load low", {15'h0, ir_load_o}, 16'h0);
    step_i = 1'b1; #1;
    chk("R4 load high", {15'h0, ir_load_o}, 16'h1);
    @(negedge clk_i);
    // decode; live bus now differs from the captured word
    data_i = ~v.instr; step_i = 1'b0;
    for (int i = 0; i < hold; i++) @(negedge clk_i);
    #1;
    chk("R2 pc held", pc_o, exp_pc);
    chk("R2 no we", {15'h0, rf_we_o}, 16'h0);
    step_i = 1'b1; #1;
    chk("R5 no load in decode", {15'h0, ir_load_o}, 16'h0);
    chk("R5 no we in decode", {15'h0, rf_we_o}, 16'h0);
    @(negedge clk_i);
    // execute
    data_i = {8'hA5, v.ld}; rf_rdata_i = v.ld; alu_res_i = v.alu; step_i = 1'b0; #1;
    chk("R12 we needs step", {15'h0, rf_we_o}, 16'h0);
    chk("R8 rd select", {15'h0, rd_o}, {15'h0, v.rd});
    chk("R7 addr", {12'h0, addr_o}, {12'h0, exp_addr});
    step_i = 1'b1; #1;
    case (op)
      4'd0: begin
        chk("R6 we", {15'h0, rf_we_o}, {15'h0, v.we});
        chk("R6 waddr", {12'h0, rf_waddr_o}, {12'h0, v.wa});
        chk("R6 wdata", {12'h0, rf_wdata_o}, {12'h0, v.wd});
        chk("R6 alu_fn", {12'h0, alu_fn_o}, {12'h0, v.instr[3:0]});
      end
      4'd1: begin
        chk("R7 we", {15'h0, rf_we_o}, {15'h0, v.we});
        chk("R7 waddr", {12'h0, rf_waddr_o}, {12'h0, v.wa});
        chk("R7 wdata", {12'h0, rf_wdata_o}, {12'h0, v.wd});
      end
      4'd2: begin
        chk("R8 we", {15'h0, rf_we_o}, 16'h0);
        chk("R8 raddr", {12'h0, rf_raddr_o}, {12'h0, v.instr[7:4]});
        chk("R8 wdata", {12'h0, wdata_o}, {12'h0, v.ld});
      end
      4'd3: begin
        chk("R9 we", {15'h0, rf_we_o}, {15'h0, v.we});
        chk("R9 waddr", {12'h0, rf_waddr_o}, {12'h0, v.wa});
        chk("R9 wdata", {12'h0, rf_wdata_o}, {12'h0, v.wd});
      end
      default: begin
        chk("R10 no we", {15'h0, rf_we_o}, 16'h0);
        chk("R10 rd", {15'h0, rd_o}, 16'h1);
      end
    endcase
    @(negedge clk_i);
    step_i = 1'b0; exp_pc = exp_pc + 16'd1; #1;
    chk("R11 pc inc", pc_o, exp_pc);
    chk("R12 we drop", {15'h0, rf_we_o}, 16'h0);
    chk("R5 back in fetch", {12'h0, addr_o}, {12'h0, exp_pc[3:0]});
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset held with step high must not advance
    step_i = 1'b1;
    repeat (3) @(negedge clk_i);
    step_i = 1'b0; #1;
    chk("R1 pc", pc_o, 16'h0);
    chk("R1 addr", {12'h0, addr_o}, 16'h0);
    chk("R1 rd", {15'h0, rd_o}, 16'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step_i = 1'b1; #1;
    chk("R1 in fetch", {15'h0, ir_load_o}, 16'h1);
    step_i = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], (i % 3) + 1);

    // run to the address wrap with unused opcodes
    for (int i = 0; i < 6; i++)
      run_vec('{12'h900 | i[11:0], 4'h0, 4'h0, 1'b0, 4'h0, 4'h0, 1'b1}, 0);
    chk("R11 pc 16", pc_o, 16'd16);
    chk("R11 addr wrap", {12'h0, addr_o}, 16'h0);

    // one more instruction after the wrap
    run_vec('{12'h341, 4'h0, 4'h0, 1'b1, 4'h4, 4'h1, 1'b1}, 0);
    chk("R11 addr after wrap", {12'h0, addr_o}, 16'h1);

    // reset in mid-instruction, between edges
    data_i = 12'h123; step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    #2 rst_ni = 1'b0; #1;
    chk("R1 async pc", pc_o, 16'h0);
    chk("R1 async addr", {12'h0, addr_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1; exp_pc = '0;
    step_i = 1'b1; #1;
    chk("R1 fetch after reset", {15'h0, ir_load_o}, 16'h1);
    step_i = 1'b0;
    run_vec(VEC[3], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule